// File: doc/BRIEF.md
# Sticky Link Status and Interrupt Register Pair

This block holds two 32-bit registers for a serial radio-link receiver. They sit on a simple read/write register bus. The status register, at byte offset 0x4, shows the receiver's present condition as live bits: signal loss, line-code-violation alarm, hyperframe sync, node radio-frame sync, and a frame-sync flag that is set only when both syncs are held. It also keeps four sticky bits. Each one latches an event so that software cannot miss it between polls: a radio frame pulse (this recurs about every 10 ms), a receive-clock frequency mismatch, a change of the frame-sync flag, and any cycle with signal loss.

Reading the status register returns its value as it stood before the read. The same read clears the sticky bits. An event that arrives in the very cycle of the read keeps its bit set, so the next read reports it. As a result, a sticky bit found during link bring-up may be left over from that period, and a second read shows the true state. The control register, at offset 0x0, holds a global interrupt enable and an enable for reset requests that arrive over the link. It also shows a read-to-clear pending flag for such requests. One registered interrupt line is derived from these bits.

Read data is registered. It appears with a valid flag one cycle after the read strobe.

Top module: `link_status_regs`

## Requirements
- R1: After reset, a read of offset 0x0 and a read of offset 0x4 both return 0, and `irq_o` is 0.
- R2: A read strobe in cycle n gives `rd_valid_o` high and the read word on `rd_data_o` in cycle n+1.
- R3: Status live bits reflect the inputs sampled one cycle earlier: bit 0 signal loss, bit 1 frame sync (hyperframe and node-frame sync both high), bit 2 hyperframe sync, bit 3 node-frame sync, bit 5 line-code-violation alarm.
- R4: Status bits 31:12, 7:6 and 4 read as 0. Control bits 31:3 read as 0.
- R5: A radio frame pulse sets status bit 11, and a frequency-mismatch pulse sets status bit 10. Each bit stays set until it is cleared.
- R6: Status bit 9 sets when the frame-sync flag changes value in either direction. Status bit 8 sets in every cycle in which signal loss is high.
- R7: A read of offset 0x4 returns the sticky bits as they were before the read and clears them.
- R8: An event in the same cycle as the clearing read leaves its sticky bit set, so the following read reports it.
- R9: Control bit 0 (global interrupt enable) and bit 1 (reset-request enable) are written from data bits 0 and 1 at offset 0x0. Writes to offset 0x4 have no effect.
- R10: Control bit 2 is a read-only pending flag. It is set by a link reset-request pulse and cleared by a read of offset 0x0.
- R11: `irq_o` is high one cycle after the state changes, when the global enable is set and either a sticky status bit is set or (reset-request enable and pending flag) are both set. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Byte offset, 0x0 control, 0x4 status |
| wr_data | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_en` |
| frame_pulse_i | input | 1 | Radio frame pulse event |
| freq_err_i | input | 1 | Receive clock frequency mismatch event |
| los_i | input | 1 | Signal loss, level |
| lcv_alarm_i | input | 1 | Line-code-violation alarm, level |
| hfn_sync_i | input | 1 | Hyperframe sync achieved, level |
| bfn_sync_i | input | 1 | Node radio-frame sync achieved, level |
| link_rst_req_i | input | 1 | Reset request received over the link, pulse |
| irq_o | output | 1 | Registered CPU interrupt |

## Verification
The assertions assume that the read and write strobes are held low during reset. They also assume that all event and level inputs change only between clock edges, so each value lasts at least one whole cycle. The stimulus drives every input on the falling clock edge and releases the strobes before reset is lifted. It then places events both apart from reads and exactly in the cycle of a clearing read, which exercises the case where an event must survive the read.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int STAT_OFS   = 4;
  localparam int CTRL_OFS   = 0;
  // status live bit positions
  localparam int B_LOS      = 0;
  localparam int B_FSYNC    = 1;
  localparam int B_HFN      = 2;
  localparam int B_BFN      = 3;
  localparam int B_LCV      = 5;
  localparam int B_HOLD_LO  = 8;
  // sticky bank ordering, index i lands at status bit B_HOLD_LO+i
  localparam int N_HOLD     = 4;
  localparam int H_LOS      = 0;
  localparam int H_STATE    = 1;
  localparam int H_FREQ     = 2;
  localparam int H_FRAME    = 3;
  // control register bits
  localparam int C_GEN      = 0;
  localparam int C_HWRST    = 1;
  localparam int C_PEND     = 2;
endpackage

// File: rtl/lsr_hold_bank.sv
module lsr_hold_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         clr,
  output logic [N-1:0] hold_q,
  output logic [N-1:0] hold_nxt
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      // an event wins over a clearing read so nothing is lost
      assign hold_nxt[i] = ev[i] | (hold_q[i] & ~clr);

      always_ff @(posedge clk) begin
        if (rst) hold_q[i] <= 1'b0;
        else     hold_q[i] <= hold_nxt[i];
      end

      AST_HOLD_SET: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> hold_q[i]); // R5
      AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !ev[i]) |=> !hold_q[i]); // R7
      AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (clr && ev[i]) |=> hold_q[i]); // R8
    end
  endgenerate
endmodule

// File: rtl/lsr_live_sample.sv
module lsr_live_sample (
  input  logic clk,
  input  logic rst,
  input  logic los_i,
  input  logic lcv_i,
  input  logic hfn_i,
  input  logic bfn_i,
  output logic los_q,
  output logic lcv_q,
  output logic hfn_q,
  output logic bfn_q,
  output logic fsync_q,
  output logic fsync_chg
);
  logic fsync_now;
  assign fsync_now = hfn_i & bfn_i;
  assign fsync_chg = fsync_now ^ fsync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      los_q   <= 1'b0;
      lcv_q   <= 1'b0;
      hfn_q   <= 1'b0;
      bfn_q   <= 1'b0;
      fsync_q <= 1'b0;
    end else begin
      los_q   <= los_i;
      lcv_q   <= lcv_i;
      hfn_q   <= hfn_i;
      bfn_q   <= bfn_i;
      fsync_q <= fsync_now;
    end
  end

  AST_FSYNC_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    fsync_q |-> (hfn_q && bfn_q)); // R3
endmodule

// File: rtl/lsr_irq_ctrl.sv
module lsr_irq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic [1:0] wr_bits,
  input  logic       pend_nxt,
  input  logic       hold_any_nxt,
  output logic       gen_en_q,
  output logic       hw_en_q,
  output logic       irq_o
);
  logic gen_nxt, hw_nxt;
  assign gen_nxt = wr_ctrl ? wr_bits[0] : gen_en_q;
  assign hw_nxt  = wr_ctrl ? wr_bits[1] : hw_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en_q <= 1'b0;
      hw_en_q  <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      gen_en_q <= gen_nxt;
      hw_en_q  <= hw_nxt;
      irq_o    <= gen_nxt & ((hw_nxt & pend_nxt) | hold_any_nxt);
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> gen_en_q); // R11
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (gen_en_q == $past(wr_bits[0]) && hw_en_q == $past(wr_bits[1]))); // R9
endmodule

// File: rtl/link_status_regs.sv
module link_status_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              frame_pulse_i,
  input  logic              freq_err_i,
  input  logic              los_i,
  input  logic              lcv_alarm_i,
  input  logic              hfn_sync_i,
  input  logic              bfn_sync_i,
  input  logic              link_rst_req_i,
  output logic              irq_o
);
  import lsr_pkg::*;

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic stat_rd, ctrl_rd, ctrl_wr;
  assign stat_rd = rd_en && (addr == A_STAT);
  assign ctrl_rd = rd_en && (addr == A_CTRL);
  assign ctrl_wr = wr_en && (addr == A_CTRL);

  logic los_q, lcv_q, hfn_q, bfn_q, fsync_q, fsync_chg;
  lsr_live_sample u_live (
    .clk(clk), .rst(rst),
    .los_i(los_i), .lcv_i(lcv_alarm_i), .hfn_i(hfn_sync_i), .bfn_i(bfn_sync_i),
    .los_q(los_q), .lcv_q(lcv_q), .hfn_q(hfn_q), .bfn_q(bfn_q),
    .fsync_q(fsync_q), .fsync_chg(fsync_chg)
  );

  logic [N_HOLD-1:0] hold_ev, hold_q, hold_nxt;
  always_comb begin
    hold_ev          = '0;
    hold_ev[H_LOS]   = los_i;
    hold_ev[H_STATE] = fsync_chg;
    hold_ev[H_FREQ]  = freq_err_i;
    hold_ev[H_FRAME] = frame_pulse_i;
  end

  lsr_hold_bank #(.N(N_HOLD)) u_stat_hold (
    .clk(clk), .rst(rst), .ev(hold_ev), .clr(stat_rd),
    .hold_q(hold_q), .hold_nxt(hold_nxt)
  );

  logic [0:0] pend_q, pend_nxt;
  lsr_hold_bank #(.N(1)) u_pend_hold (
    .clk(clk), .rst(rst), .ev(link_rst_req_i), .clr(ctrl_rd),
    .hold_q(pend_q), .hold_nxt(pend_nxt)
  );

  logic gen_en_q, hw_en_q;
  lsr_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .wr_ctrl(ctrl_wr), .wr_bits(wr_data[1:0]),
    .pend_nxt(pend_nxt[0]), .hold_any_nxt(|hold_nxt),
    .gen_en_q(gen_en_q), .hw_en_q(hw_en_q), .irq_o(irq_o)
  );

  logic [DATA_W-1:0] stat_word, ctrl_word;
  always_comb begin
    stat_word          = '0;
    stat_word[B_LOS]   = los_q;
    stat_word[B_FSYNC] = fsync_q;
    stat_word[B_HFN]   = hfn_q;
    stat_word[B_BFN]   = bfn_q;
    stat_word[B_LCV]   = lcv_q;
    stat_word[B_HOLD_LO +: N_HOLD] = hold_q;
    ctrl_word          = '0;
    ctrl_word[C_GEN]   = gen_en_q;
    ctrl_word[C_HWRST] = hw_en_q;
    ctrl_word[C_PEND]  = pend_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en;
      if (stat_rd)      rd_data_o <= stat_word;
      else if (ctrl_rd) rd_data_o <= ctrl_word;
      else              rd_data_o <= '0;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid_o); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (rd_data_o[31:12] == 20'h0 && rd_data_o[7:6] == 2'b00 && !rd_data_o[4])); // R4
  AST_PEND_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q[0]) |-> $past(link_rst_req_i)); // R10
endmodule

// File: tb/link_status_regs_bench.sv
module link_status_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 0, wr_en = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data_o;
  logic rd_valid_o, irq_o;
  logic frame_pulse_i = 0, freq_err_i = 0, los_i = 0, lcv_alarm_i = 0;
  logic hfn_sync_i = 0, bfn_sync_i = 0, link_rst_req_i = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_status_regs u_link_status_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .frame_pulse_i(frame_pulse_i), .freq_err_i(freq_err_i), .los_i(los_i),
    .lcv_alarm_i(lcv_alarm_i), .hfn_sync_i(hfn_sync_i), .bfn_sync_i(bfn_sync_i),
    .link_rst_req_i(link_rst_req_i), .irq_o(irq_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word for every valid read result
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) chk("R2 unexpected read data", rd_data_o, 32'hx);
      else chk(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
    end
  end

  task automatic do_read(logic [3:0] a, logic [31:0] exp, string tag, bit with_freq = 0);
    @(negedge clk);
    addr = a; rd_en = 1; freq_err_i = with_freq;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0; freq_err_i = 0;
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_pulse_i = 1;
    @(negedge clk); frame_pulse_i = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); link_rst_req_i = 1;
    @(negedge clk); link_rst_req_i = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 irq after reset", {31'b0, irq_o}, 0);
    do_read(4'h4, 32'h0, "R1 status after reset");
    do_read(4'h0, 32'h0, "R1 control after reset");

    // live sync bits, frame-sync change latches bit 9
    hfn_sync_i = 1;
    do_read(4'h4, 32'h0000_0004, "R3 hfn only");
    bfn_sync_i = 1;
    do_read(4'h4, 32'h0000_020E, "R6 fsync change sticky");
    do_read(4'h4, 32'h0000_000E, "R7 sticky cleared");

    // signal loss level; last loss cycle coincides with the clearing read
    los_i = 1;
    @(negedge clk);
    do_read(4'h4, 32'h0000_010F, "R6 los sticky and live");
    los_i = 0;
    do_read(4'h4, 32'h0000_010E, "R8 los kept across read");
    do_read(4'h4, 32'h0000_000E, "R7 second read true value");

    // frame pulse with interrupts disabled
    pulse_frame();
    chk("R11 irq gated off", {31'b0, irq_o}, 0);
    do_read(4'h4, 32'h0000_080E, "R5 frame pulse sticky");
    do_read(4'h4, 32'h0000_000E, "R7 frame cleared");

    // frequency mismatch exactly in the read cycle
    do_read(4'h4, 32'h0000_000E, "R8 read returns pre-event value", 1);
    do_read(4'h4, 32'h0000_040E, "R8 freq event kept");
    do_read(4'h4, 32'h0000_000E, "R5 freq cleared");

    // LCV alarm live
    lcv_alarm_i = 1;
    do_read(4'h4, 32'h0000_002E, "R3 lcv live");
    lcv_alarm_i = 0;
    do_read(4'h4, 32'h0000_000E, "R3 lcv dropped");

    // interrupt control
    do_write(4'h0, 32'h0000_0003);
    chk("R11 no source", {31'b0, irq_o}, 0);
    do_read(4'h0, 32'h0000_0003, "R9 enables written");
    pulse_frame();
    chk("R11 irq from sticky", {31'b0, irq_o}, 1);
    do_read(4'h4, 32'h0000_080E, "R5 frame for irq");
    chk("R11 irq drops after clear", {31'b0, irq_o}, 0);
    pulse_req();
    chk("R11 irq from reset request", {31'b0, irq_o}, 1);
    do_read(4'h0, 32'h0000_0007, "R10 pending set");
    chk("R10 irq drops after control read", {31'b0, irq_o}, 0);
    do_read(4'h0, 32'h0000_0003, "R10 pending cleared");
    do_write(4'h0, 32'h0000_0001);
    pulse_req();
    chk("R11 reset request not enabled", {31'b0, irq_o}, 0);
    do_read(4'h0, 32'h0000_0005, "R10 pending without enable");
    do_read(4'h0, 32'h0000_0001, "R10 cleared again");

    // writes to status ignored, reserved bits stay zero
    do_write(4'h4, 32'hFFFF_FFFF);
    do_read(4'h0, 32'h0000_0001, "R9 status write ignored ctrl");
    do_read(4'h4, 32'h0000_000E, "R9 status write ignored");
    do_write(4'h0, 32'hFFFF_FFF8);
    do_read(4'h0, 32'h0000_0000, "R4 control upper bits zero");
    los_i = 1; lcv_alarm_i = 1;
    @(negedge clk);
    do_read(4'h4, 32'h0000_012F, "R4 reserved zero all live high");

    repeat (3) @(negedge clk);
    chk("R2 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule